// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer datapath of the execute stage of a 32-bit load/store core that uses the classic three-register / register-immediate instruction encoding. It receives the full instruction word together with the two source operand values already read from the register file. In the same cycle, with no clock, it returns the computed value, the destination register index and a write enable. The write enable already accounts for writes to register zero and for arithmetic overflow.

The unit decodes the primary opcode and, for register-register forms, the function field itself. It handles:
- addition and subtraction, in trapping and wrapping variants;
- bitwise AND, OR and XOR;
- signed and unsigned set-on-less-than;
- shifts by a constant or by a register amount;
- loading a constant into the upper half of a register.

Signed overflow does not raise an exception here. It is reported on a flag for the surrounding pipeline to turn into a trap. Encodings outside the supported set produce a quiet, non-writing result.

Top module: `exu_int_alu`

## Requirements
- R1: Register forms with opcode 000000 and function 0x20 (trapping add), 0x21 (wrapping add), 0x22 (trapping subtract) and 0x23 (wrapping subtract) return rs+rt or rs-rt modulo 2^32.
- R2: Register forms with function 0x24, 0x25 and 0x26 return rs AND rt, rs OR rt and rs XOR rt.
- R3: ovf_o is 1 exactly when function 0x20, function 0x22 or opcode 001000 (add immediate) overflows as a signed 32-bit operation. Function 0x21, function 0x23 and opcode 001001 never set ovf_o. While ovf_o is 1, wr_en_o is 0 and result_o holds the wrapped value.
- R4: Function 0x2A and opcode 001010 compare rs with the second operand as signed numbers. Function 0x2B and opcode 001011 compare them as unsigned numbers. The result is 1 if rs is smaller and 0 otherwise.
- R5: Function 0x00 shifts rt left, 0x02 shifts it right with zero fill, and 0x03 shifts it right with sign fill. The amount is instruction bits 10:6.
- R6: Function 0x04 shifts rt left and 0x06 shifts it right with zero fill. The amount is rs bits 4:0, and the upper bits of rs are ignored.
- R7: The 16-bit immediate in bits 15:0 is sign-extended for opcodes 001000, 001001, 001010 and 001011. It is zero-extended for opcodes 001100 (AND), 001101 (OR) and 001110 (XOR).
- R8: Opcode 001111 returns the immediate in bits 31:16 with bits 15:0 zero, and ignores rs.
- R9: dest_o is instruction bits 15:11 for register forms and bits 20:16 for immediate forms.
- R10: wr_en_o is 0 whenever dest_o is 0. The all-zero instruction word gives wr_en_o=0 and ovf_o=0.
- R11: Any other opcode, or any other function code under opcode 000000, gives result_o=0, dest_o=0, wr_en_o=0 and ovf_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| result_o | output | 32 | Computed value |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The hardest situations to reach are the overflow boundaries and the sign edge of the signed compare. They only occur when the operands sit at or next to the most negative and most positive values. They matter most for subtraction and for sign-extended immediates, where the second operand is negated or widened before the add. The bench therefore sweeps every supported operation over a cross product of edge operands, including 0x7FFFFFFF, 0x80000000, all-ones and 0xFFFF8000. It runs every shift amount from 0 to 31 for both the constant and the register-amount shifts, and then adds random operands. The expected values are derived from wide signed arithmetic in the bench.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;

    localparam int DATA_W   = 32;
    localparam int SHAMT_W  = $clog2(DATA_W);
    localparam int REG_W    = 5;
    localparam int IMM_W    = 16;
    localparam int OPC_W    = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_ADDIW = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
    localparam logic [OPC_W-1:0] OPC_UPPER = 6'b001111;

    localparam logic [5:0] FN_SHL    = 6'h00;
    localparam logic [5:0] FN_SHR    = 6'h02;
    localparam logic [5:0] FN_SHRA   = 6'h03;
    localparam logic [5:0] FN_SHLV   = 6'h04;
    localparam logic [5:0] FN_SHRV   = 6'h06;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_ADDW   = 6'h21;
    localparam logic [5:0] FN_SUB    = 6'h22;
    localparam logic [5:0] FN_SUBW   = 6'h23;
    localparam logic [5:0] FN_AND    = 6'h24;
    localparam logic [5:0] FN_OR     = 6'h25;
    localparam logic [5:0] FN_XOR    = 6'h26;
    localparam logic [5:0] FN_LTS    = 6'h2A;
    localparam logic [5:0] FN_LTU    = 6'h2B;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_LTS, K_LTU,
        K_SHL, K_SHR, K_SHRA, K_UPPER, K_NONE
    } alu_kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsrc_e;

    typedef struct packed {
        logic             valid;
        alu_kind_e        kind;
        bsrc_e            bsrc;
        logic             chk_ovf;
        logic             var_amt;
        logic [REG_W-1:0] dest;
    } exu_ctrl_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_alu_pkg::*;
(
    input  logic [DATA_W-1:0] instr_i,
    output exu_ctrl_t         ctrl_o
);

    logic [OPC_W-1:0] opc;
    logic [5:0]       fn;
    logic [REG_W-1:0] rt_idx;
    logic [REG_W-1:0] rd_idx;

    assign opc    = instr_i[31:26];
    assign fn     = instr_i[5:0];
    assign rt_idx = instr_i[20:16];
    assign rd_idx = instr_i[15:11];

    always_comb begin
        ctrl_o         = '0;
        ctrl_o.kind    = K_NONE;
        ctrl_o.bsrc    = B_REG;
        if (opc == OPC_REG) begin
            ctrl_o.valid = 1'b1;
            ctrl_o.dest  = rd_idx;
            unique case (fn)
                FN_ADD:  begin ctrl_o.kind = K_ADD; ctrl_o.chk_ovf = 1'b1; end
                FN_ADDW: ctrl_o.kind = K_ADD;
                FN_SUB:  begin ctrl_o.kind = K_SUB; ctrl_o.chk_ovf = 1'b1; end
                FN_SUBW: ctrl_o.kind = K_SUB;
                FN_AND:  ctrl_o.kind = K_AND;
                FN_OR:   ctrl_o.kind = K_OR;
                FN_XOR:  ctrl_o.kind = K_XOR;
                FN_LTS:  ctrl_o.kind = K_LTS;
                FN_LTU:  ctrl_o.kind = K_LTU;
                FN_SHL:  ctrl_o.kind = K_SHL;
                FN_SHR:  ctrl_o.kind = K_SHR;
                FN_SHRA: ctrl_o.kind = K_SHRA;
                FN_SHLV: begin ctrl_o.kind = K_SHL; ctrl_o.var_amt = 1'b1; end
                FN_SHRV: begin ctrl_o.kind = K_SHR; ctrl_o.var_amt = 1'b1; end
                default: begin ctrl_o.valid = 1'b0; ctrl_o.dest = '0; end
            endcase
        end else begin
            ctrl_o.valid = 1'b1;
            ctrl_o.dest  = rt_idx;
            unique case (opc)
                OPC_ADDI:  begin ctrl_o.kind = K_ADD; ctrl_o.bsrc = B_SEXT; ctrl_o.chk_ovf = 1'b1; end
                OPC_ADDIW: begin ctrl_o.kind = K_ADD; ctrl_o.bsrc = B_SEXT; end
                OPC_SLTI:  begin ctrl_o.kind = K_LTS; ctrl_o.bsrc = B_SEXT; end
                OPC_SLTIU: begin ctrl_o.kind = K_LTU; ctrl_o.bsrc = B_SEXT; end
                OPC_ANDI:  begin ctrl_o.kind = K_AND; ctrl_o.bsrc = B_ZEXT; end
                OPC_ORI:   begin ctrl_o.kind = K_OR;  ctrl_o.bsrc = B_ZEXT; end
                OPC_XORI:  begin ctrl_o.kind = K_XOR; ctrl_o.bsrc = B_ZEXT; end
                OPC_UPPER: ctrl_o.kind = K_UPPER;
                default:   begin ctrl_o.valid = 1'b0; ctrl_o.dest = '0; end
            endcase
        end
    end

    // R11: a rejected encoding must never request an overflow check
    always_comb begin
        if (!ctrl_o.valid) begin
            a_r11_invalid_no_check: assert (!ctrl_o.chk_ovf && ctrl_o.kind == K_NONE);
        end
    end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub
    import exu_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         chk_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    assign b_eff  = sub_i ? ~b_i : b_i;
    assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    assign sum_o  = wide[W-1:0];
    assign ovf_o  = chk_i & (a_i[MSB] == b_eff[MSB]) & (sum_o[MSB] != a_i[MSB]);
    assign lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    assign lt_u_o = ~wide[W];

    // R3: operands of opposite effective sign can never overflow
    always_comb begin
        if (!sub_i && (a_i[MSB] != b_i[MSB])) begin
            a_r3_no_overflow: assert (!ovf_o);
        end
        if (sub_i && (a_i[MSB] == b_i[MSB])) begin
            a_r3_no_overflow_sub: assert (!ovf_o);
        end
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  res_o
);

    logic [W-1:0] stage [0:SW];
    logic [W-1:0] in_rev;
    logic [W-1:0] out_rev;
    logic         fill;

    assign fill = arith_i & ~left_i & val_i[W-1];

    generate
        for (genvar b = 0; b < W; b++) begin : g_rev
            assign in_rev[b]  = val_i[W-1-b];
            assign out_rev[b] = stage[SW][W-1-b];
        end
    endgenerate

    assign stage[0] = left_i ? in_rev : val_i;

    generate
        for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amt_i[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
        end
    endgenerate

    assign res_o = left_i ? out_rev : stage[SW];

    // R5: zero amount passes the value; arithmetic right shift keeps the sign
    always_comb begin
        if (amt_i == '0) begin
            a_r5_zero_amount_identity: assert (res_o == val_i);
        end
        if (arith_i && !left_i) begin
            a_r5_sign_fill: assert (res_o[W-1] == val_i[W-1]);
        end
    end

endmodule

// File: rtl/exu_int_alu.sv
module exu_int_alu
    import exu_alu_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic [4:0]  dest_o,
    output logic        wr_en_o,
    output logic        ovf_o
);

    exu_ctrl_t           ctrl;
    logic [DATA_W-1:0]   opb;
    logic [IMM_W-1:0]    imm;
    logic [DATA_W-1:0]   sum;
    logic                ovf_raw;
    logic                lt_s;
    logic                lt_u;
    logic [DATA_W-1:0]   sh_res;
    logic [SHAMT_W-1:0]  sh_amt;

    assign imm = instr_i[IMM_W-1:0];

    exu_decode u_dec (
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    always_comb begin
        unique case (ctrl.bsrc)
            B_SEXT:  opb = sext_imm(imm);
            B_ZEXT:  opb = zext_imm(imm);
            default: opb = rt_val_i;
        endcase
    end

    exu_addsub #(.W(DATA_W)) u_add (
        .a_i    (rs_val_i),
        .b_i    (opb),
        .sub_i  (ctrl.kind != K_ADD),
        .chk_i  (ctrl.chk_ovf),
        .sum_o  (sum),
        .ovf_o  (ovf_raw),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    assign sh_amt = ctrl.var_amt ? rs_val_i[SHAMT_W-1:0] : instr_i[6 +: SHAMT_W];

    exu_shifter #(.W(DATA_W), .SW(SHAMT_W)) u_sh (
        .val_i   (rt_val_i),
        .amt_i   (sh_amt),
        .left_i  (ctrl.kind == K_SHL),
        .arith_i (ctrl.kind == K_SHRA),
        .res_o   (sh_res)
    );

    always_comb begin
        unique case (ctrl.kind)
            K_ADD, K_SUB:         result_o = sum;
            K_AND:                result_o = rs_val_i & opb;
            K_OR:                 result_o = rs_val_i | opb;
            K_XOR:                result_o = rs_val_i ^ opb;
            K_LTS:                result_o = {{(DATA_W-1){1'b0}}, lt_s};
            K_LTU:                result_o = {{(DATA_W-1){1'b0}}, lt_u};
            K_SHL, K_SHR, K_SHRA: result_o = sh_res;
            K_UPPER:              result_o = {imm, {(DATA_W-IMM_W){1'b0}}};
            default:              result_o = '0;
        endcase
    end

    assign ovf_o   = ctrl.valid & ovf_raw;
    assign dest_o  = ctrl.dest;
    assign wr_en_o = ctrl.valid & (ctrl.dest != '0) & ~ovf_o;

    always_comb begin
        if (dest_o == '0) begin
            a_r10_no_write_reg0: assert (!wr_en_o);
        end
        if (ovf_o) begin
            a_r3_ovf_blocks_write: assert (!wr_en_o);
        end
        if (instr_i == '0) begin
            a_r10_zero_word_quiet: assert (!wr_en_o && !ovf_o);
        end
    end

endmodule

// File: tb/exu_int_alu_tb.sv
module exu_int_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr, rs_v, rt_v;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en, ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    exu_int_alu dut_i (
        .instr_i  (instr),
        .rs_val_i (rs_v),
        .rt_val_i (rt_v),
        .result_o (result),
        .dest_o   (dest),
        .wr_en_o  (wr_en),
        .ovf_o    (ovf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h0000_FFFF;
            6: return 32'hFFFF_8000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] rform(input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
        return {6'd0, 5'd3, 5'd4, rd, sh, fn};
    endfunction

    function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
        return {op, 5'd7, rt, imm};
    endfunction

    function automatic bit sovf(input logic [31:0] a, input logic [31:0] b, input bit neg);
        longint s;
        s = neg ? (longint'($signed(a)) - longint'($signed(b)))
                : (longint'($signed(a)) + longint'($signed(b)));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic ref_model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] r, output logic [4:0] d, output bit we,
                             output bit ov, output bit valid, output string tag);
        logic [31:0] se, ze;
        logic [4:0]  sh;
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0, ins[15:0]};
        sh = ins[10:6];
        r = 0; ov = 0; valid = 1; d = 0; tag = "R11";
        if (ins[31:26] == 6'd0) begin
            d = ins[15:11];
            case (ins[5:0])
                6'h20: begin r = a + b; ov = sovf(a, b, 0); tag = "R1"; end
                6'h21: begin r = a + b; tag = "R1"; end
                6'h22: begin r = a - b; ov = sovf(a, b, 1); tag = "R1"; end
                6'h23: begin r = a - b; tag = "R1"; end
                6'h24: begin r = a & b; tag = "R2"; end
                6'h25: begin r = a | b; tag = "R2"; end
                6'h26: begin r = a ^ b; tag = "R2"; end
                6'h2A: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
                6'h2B: begin r = (a < b) ? 1 : 0; tag = "R4"; end
                6'h00: begin r = b << sh; tag = "R5"; end
                6'h02: begin r = b >> sh; tag = "R5"; end
                6'h03: begin r = $signed(b) >>> sh; tag = "R5"; end
                6'h04: begin r = b << a[4:0]; tag = "R6"; end
                6'h06: begin r = b >> a[4:0]; tag = "R6"; end
                default: begin valid = 0; d = 0; end
            endcase
        end else begin
            d = ins[20:16];
            case (ins[31:26])
                6'b001000: begin r = a + se; ov = sovf(a, se, 0); tag = "R7"; end
                6'b001001: begin r = a + se; tag = "R7"; end
                6'b001010: begin r = ($signed(a) < $signed(se)) ? 1 : 0; tag = "R4"; end
                6'b001011: begin r = (a < se) ? 1 : 0; tag = "R4"; end
                6'b001100: begin r = a & ze; tag = "R7"; end
                6'b001101: begin r = a | ze; tag = "R7"; end
                6'b001110: begin r = a ^ ze; tag = "R7"; end
                6'b001111: begin r = {ins[15:0], 16'h0}; tag = "R8"; end
                default:   begin valid = 0; d = 0; end
            endcase
        end
        we = valid && (d != 0) && !ov;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er; logic [4:0] ed; bit ew, eo, ev; string tg;
        @(negedge clk);
        instr = ins; rs_v = a; rt_v = b;
        #1;
        ref_model(ins, a, b, er, ed, ew, eo, ev, tg);
        chk(tg, "result", result, er);
        chk(ev ? "R9" : "R11", "dest", {27'd0, dest}, {27'd0, ed});
        chk(ev ? "R10" : "R11", "wr_en", {31'd0, wr_en}, {31'd0, ew});
        chk(ev ? "R3" : "R11", "ovf", {31'd0, ovf}, {31'd0, eo});
    endtask

    localparam logic [5:0] FNS [14] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
                                        6'h2A, 6'h2B, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06};

    initial begin
        instr = 0; rs_v = 0; rt_v = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R10: all-zero word with arbitrary operands has no visible write
        run(32'h0, 32'hDEAD_BEEF, 32'h1357_9BDF);

        // R1 R2 R4 R5 R6: register forms over the operand corner cross product
        for (int f = 0; f < 14; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(rform(5'((f + i + j) % 32), 5'(i * 5 + j), FNS[f]), corner(i), corner(j));

        // R7 R4 R8: immediate forms; R3 covers add-immediate overflow at edges
        for (int op = 8; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(iform(6'(op), 5'((op + i * 3 + j) % 32), corner(j)[15:0] ^ 16'(j << 13)),
                        corner(i), corner(j));

        // R5 R6: every shift amount, variable forms with junk in upper rs bits
        for (int s = 0; s < 32; s++) begin
            run(rform(5'd9, 5'(s), 6'h00), 32'h0, 32'h8765_4321);
            run(rform(5'd9, 5'(s), 6'h02), 32'h0, 32'h8765_4321);
            run(rform(5'd9, 5'(s), 6'h03), 32'h0, 32'h8765_4321);
            run(rform(5'd9, 5'(s), 6'h03), 32'h0, 32'h4765_4321);
            run(rform(5'd10, 5'd0, 6'h04), 32'hFFFF_FFE0 | 32'(s), 32'hC000_0003);
            run(rform(5'd10, 5'd0, 6'h06), 32'hA5A5_A5E0 | 32'(s), 32'hC000_0003);
        end

        // R3: exact signed boundaries
        run(rform(5'd1, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h1);
        run(rform(5'd1, 5'd0, 6'h21), 32'h7FFF_FFFF, 32'h1);
        run(rform(5'd1, 5'd0, 6'h22), 32'h8000_0000, 32'h1);
        run(rform(5'd1, 5'd0, 6'h23), 32'h8000_0000, 32'h1);
        run(rform(5'd1, 5'd0, 6'h22), 32'h0, 32'h8000_0000);
        run(iform(6'b001000, 5'd2, 16'h8000), 32'h8000_0000, 32'h0);
        run(iform(6'b001001, 5'd2, 16'h8000), 32'h8000_0000, 32'h0);

        // R8: upper-immediate ignores rs
        run(iform(6'b001111, 5'd5, 16'hBEEF), 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R11: unsupported encodings are quiet
        run({6'd0, 5'd1, 5'd2, 5'd3, 5'd4, 6'h07}, 32'h5, 32'h80000000);
        run({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h08}, 32'h5, 32'h6);
        run({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h18}, 32'h5, 32'h6);
        run({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h27}, 32'h5, 32'h6);
        run({6'b000010, 26'h3FF_FFFF}, 32'h5, 32'h6);
        run({6'b000100, 5'd1, 5'd2, 16'h10}, 32'h5, 32'h5);
        run({6'b100011, 5'd1, 5'd2, 16'h10}, 32'h5, 32'h5);
        run({6'b101011, 5'd1, 5'd2, 16'h10}, 32'h5, 32'h5);

        // random sweep over all supported forms
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            if (n % 2 == 0) w = {6'd0, $urandom_range(31, 0)[4:0], $urandom_range(31, 0)[4:0],
                                  $urandom_range(31, 0)[4:0], $urandom_range(31, 0)[4:0],
                                  FNS[$urandom_range(13, 0)]};
            else            w = {6'($urandom_range(15, 8)), $urandom()[25:0]};
            run(w, $urandom(), $urandom());
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule